// File: doc/BRIEF.md
# Parallel Display Bus Pixel Serializer

This block feeds a display panel over a narrow parallel bus. Software picks a pixel depth (12, 16, 18 or 24 bits) and a bus width (8, 9, 12 or 16 lines). It starts a frame by giving a pixel count and pulsing a start request. The block then takes pixels from a valid/ready stream. It cuts each pixel, or each pair of pixels, into bus words, most significant part first. It hands the words one at a time to an external strobe timing generator. It waits for that generator's done handshake before it presents the next word. After the last word of the last pixel is acknowledged, the block drops its own frame-active flag and emits a one-cycle frame-done pulse.

Between frames the same bus carries panel command and parameter words. A select line tells the panel which kind of word it is receiving. Commands are given as a byte count followed by a stream of words. They are only accepted when the bus is 8 or 16 lines wide.

Top module: `pbs_serializer`

## Requirements
- R1: After reset, bus_req, frame_busy, frame_done, busy_err, len_err, pix_ready and cw_ready are all 0.
- R2: The depth/width pair is legal only when the pixel bits equal 1, 2 or 3 bus widths, or exactly 1.5 bus widths. cfg_depth encodes 0=12, 1=16, 2=18, 3=24 bits. cfg_lines encodes 0=8, 1=9, 2=12, 3=16 lines. An illegal pair drives fmt_err high, and a start request is then ignored: frame_busy stays 0 and no word is sent.
- R3: When pixel bits equal bus width, each pixel is sent as one word.
- R4: When pixel bits are twice the bus width, each pixel is sent as two words: upper half first, then lower half.
- R5: When pixel bits are three bus widths, each pixel is sent as three words, most significant third first. For example, a 24-bit pixel on 8 lines goes out as bits 23:16, 15:8, 7:0.
- R6: When pixel bits are 1.5 bus widths, two pixels go out as three words. Word 1 is the top full word of pixel 0. Word 2 holds pixel 0's remaining half in its upper half and pixel 1's top half in its lower half. Word 3 is the remaining full word of pixel 1.
- R7: In the 1.5 format, an odd final pixel goes out alone as two words: its bits left-aligned, with zeros padding the low end.
- R8: A start with a nonzero count raises frame_busy on the next cycle. frame_busy falls in the cycle after the last word is acknowledged, and frame_done pulses for exactly that one cycle. A start with count 0 pulses frame_done on the next cycle and sends nothing.
- R9: bus_req stays high, with bus_data and bus_dc stable, until bus_ack. Each acknowledged request carries exactly one word. Words appear right-aligned on bus_data.
- R10: bus_dc is 0 for command words and 1 for parameter and pixel words.
- R11: On 8 lines, a command of N bytes sends N words, each taken from cw_data[7:0]. On 16 lines, a command of N bytes sends N/2 words from cw_data[15:0]. An odd N on 16 lines, or any command on 9 or 12 lines, sets the sticky len_err and sends nothing.
- R12: A start or command request made while the block is not idle is ignored and sets the sticky busy_err. The running frame still sends exactly its original pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_lines | input | 2 | Bus width code |
| fmt_err | output | 1 | Depth/width pair is illegal |
| start_req | input | 1 | Frame start pulse |
| pix_count | input | PCNT_W | Pixels in the frame, sampled with start_req |
| frame_busy | output | 1 | Frame in progress (self-clearing enable) |
| frame_done | output | 1 | One-cycle pulse at frame end |
| busy_err | output | 1 | Sticky: request made while not idle |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_data | input | 24 | Pixel, right-aligned |
| cmd_start | input | 1 | Command/parameter sequence start pulse |
| cmd_param | input | 1 | 1 = parameter words, 0 = command words |
| cmd_len | input | LEN_W | Byte count of the sequence |
| len_err | output | 1 | Sticky: illegal command length or width |
| cw_valid | input | 1 | Command word stream valid |
| cw_ready | output | 1 | Command word stream ready |
| cw_data | input | 16 | Command word, right-aligned |
| bus_req | output | 1 | Word transfer request to strobe generator |
| bus_dc | output | 1 | Data/command select for the word |
| bus_data | output | 16 | Bus word, right-aligned |
| bus_ack | input | 1 | Strobe generator done handshake |

## Verification
The assertions assume that bus_ack is only raised while bus_req is high. They also assume that cfg_depth and cfg_lines do not change while a frame or command sequence is running. The strobe model in the stimulus acknowledges only a request it has already seen, and drops the acknowledge on the following cycle. Configuration is changed only between scenarios, after frame_done or after the command words have drained.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int PIX_W = 24;
    localparam int BUS_W = 16;
    localparam int GRP_W = 2 * PIX_W;

    typedef enum logic [1:0] {DEPTH_12, DEPTH_16, DEPTH_18, DEPTH_24} depth_e;
    typedef enum logic [1:0] {LINES_8, LINES_9, LINES_12, LINES_16} lines_e;
    typedef enum logic [1:0] {FMT_1_1, FMT_2_1, FMT_3_1, FMT_3_2} fmt_e;
    typedef enum logic [2:0] {ST_IDLE, ST_PIX0, ST_PIX1, ST_SEND, ST_CWAIT} st_e;

    typedef struct packed {
        logic       legal;
        fmt_e       fmt;
        logic [4:0] pbits;
        logic [4:0] lbits;
    } busfmt_t;

    function automatic logic [4:0] depth_bits(depth_e d);
        case (d)
            DEPTH_12: return 5'd12;
            DEPTH_16: return 5'd16;
            DEPTH_18: return 5'd18;
            default:  return 5'd24;
        endcase
    endfunction

    function automatic logic [4:0] lines_bits(lines_e l);
        case (l)
            LINES_8:  return 5'd8;
            LINES_9:  return 5'd9;
            LINES_12: return 5'd12;
            default:  return 5'd16;
        endcase
    endfunction

    function automatic busfmt_t pick_format(depth_e d, lines_e l);
        busfmt_t r;
        int p;
        int n;
        p = int'(depth_bits(d));
        n = int'(lines_bits(l));
        r.pbits = depth_bits(d);
        r.lbits = lines_bits(l);
        r.legal = 1'b1;
        if (p == n)             r.fmt = FMT_1_1;
        else if (p == 2 * n)    r.fmt = FMT_2_1;
        else if (p == 3 * n)    r.fmt = FMT_3_1;
        else if (2 * p == 3 * n) r.fmt = FMT_3_2;
        else begin
            r.fmt   = FMT_1_1;
            r.legal = 1'b0;
        end
        return r;
    endfunction

    // words for one pixel sent on its own
    function automatic logic [1:0] single_words(fmt_e f);
        case (f)
            FMT_1_1: return 2'd1;
            FMT_2_1: return 2'd2;
            FMT_3_1: return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    // left-align a right-aligned pixel of p bits in the group register
    function automatic logic [GRP_W-1:0] align_one(logic [PIX_W-1:0] pix, logic [4:0] p);
        logic [PIX_W-1:0] m;
        m = pix & ((PIX_W'(1) << p) - PIX_W'(1));
        return {m, {PIX_W{1'b0}}} << (5'd24 - p);
    endfunction

    function automatic logic [GRP_W-1:0] align_pair(logic [PIX_W-1:0] a,
                                                    logic [PIX_W-1:0] b,
                                                    logic [4:0] p);
        return align_one(a, p) | (align_one(b, p) >> p);
    endfunction

endpackage

// File: rtl/pbs_fmt_decode.sv
module pbs_fmt_decode
    import pbs_pkg::*;
(
    input  depth_e     depth,
    input  lines_e     lines,
    output logic       legal,
    output fmt_e       fmt,
    output logic [4:0] pbits,
    output logic [4:0] lbits
);
    busfmt_t f;

    always_comb begin
        f     = pick_format(depth, lines);
        legal = f.legal;
        fmt   = f.fmt;
        pbits = f.pbits;
        lbits = f.lbits;
    end
endmodule

// File: rtl/pbs_packer.sv
module pbs_packer
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic [BUS_W-1:0]  cw_data,
    input  logic [4:0]        pbits,
    input  logic [4:0]        lbits,
    input  logic              cap_p0,
    input  logic              ld_single,
    input  logic              ld_pair,
    input  logic              ld_cmd,
    input  logic              shift,
    output logic [BUS_W-1:0]  word
);
    logic [PIX_W-1:0] p0_q;
    logic [GRP_W-1:0] grp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            p0_q  <= '0;
            grp_q <= '0;
        end else begin
            if (cap_p0)
                p0_q <= pix_data;
            if (ld_single)
                grp_q <= align_one(pix_data, pbits);
            else if (ld_pair)
                grp_q <= align_pair(p0_q, pix_data, pbits);
            else if (ld_cmd)
                grp_q <= {cw_data, {(GRP_W-BUS_W){1'b0}}} << (5'd16 - lbits);
            else if (shift)
                grp_q <= grp_q << lbits;
        end
    end

    // top lbits of the group, right-aligned on the bus
    assign word = grp_q[GRP_W-1 -: BUS_W] >> (5'd16 - lbits);
endmodule

// File: rtl/pbs_seq.sv
module pbs_seq
    import pbs_pkg::*;
#(
    parameter int PCNT_W = 20,
    parameter int LEN_W  = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              legal,
    input  fmt_e              fmt,
    input  lines_e            lines,
    input  logic              start_req,
    input  logic [PCNT_W-1:0] pix_count,
    input  logic              cmd_start,
    input  logic              cmd_param,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              pix_valid,
    input  logic              cw_valid,
    input  logic              bus_ack,
    output logic              pix_ready,
    output logic              cw_ready,
    output logic              bus_req,
    output logic              bus_dc,
    output logic              cap_p0,
    output logic              ld_single,
    output logic              ld_pair,
    output logic              ld_cmd,
    output logic              shift,
    output logic              frame_busy,
    output logic              frame_done,
    output logic              busy_err,
    output logic              len_err
);
    st_e               state;
    logic [PCNT_W-1:0] pix_left;
    logic [LEN_W-1:0]  cmd_left;
    logic [1:0]        wcnt;
    logic              in_frame, dc_q, done_q, berr_q, lerr_q;
    logic              pix_hs, cw_hs, xfer, go_pair;
    logic              cmd_ok;
    logic [LEN_W-1:0]  cmd_words;

    assign pix_ready = (state == ST_PIX0) || (state == ST_PIX1);
    assign cw_ready  = (state == ST_CWAIT);
    assign bus_req   = (state == ST_SEND);
    assign bus_dc    = dc_q;
    assign pix_hs    = pix_ready && pix_valid;
    assign cw_hs     = cw_ready && cw_valid;
    assign xfer      = bus_req && bus_ack;
    assign go_pair   = (state == ST_PIX0) && (fmt == FMT_3_2) && (pix_left > PCNT_W'(1));
    assign cap_p0    = pix_hs && go_pair;
    assign ld_single = pix_hs && (state == ST_PIX0) && !go_pair;
    assign ld_pair   = pix_hs && (state == ST_PIX1);
    assign ld_cmd    = cw_hs;
    assign shift     = xfer;

    assign frame_busy = in_frame;
    assign frame_done = done_q;
    assign busy_err   = berr_q;
    assign len_err    = lerr_q;

    // command length legality and word count per bus width
    always_comb begin
        cmd_ok    = 1'b0;
        cmd_words = '0;
        case (lines)
            LINES_8: begin
                cmd_ok    = 1'b1;
                cmd_words = cmd_len;
            end
            LINES_16: begin
                cmd_ok    = !cmd_len[0];
                cmd_words = cmd_len >> 1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pix_left <= '0;
            cmd_left <= '0;
            wcnt     <= '0;
            in_frame <= 1'b0;
            dc_q     <= 1'b0;
            done_q   <= 1'b0;
            berr_q   <= 1'b0;
            lerr_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        if (cmd_start)
                            berr_q <= 1'b1;
                        if (legal) begin
                            if (pix_count == '0) begin
                                done_q <= 1'b1;
                            end else begin
                                pix_left <= pix_count;
                                in_frame <= 1'b1;
                                dc_q     <= 1'b1;
                                state    <= ST_PIX0;
                            end
                        end
                    end else if (cmd_start) begin
                        if (!cmd_ok) begin
                            lerr_q <= 1'b1;
                        end else if (cmd_words != '0) begin
                            cmd_left <= cmd_words;
                            dc_q     <= cmd_param;
                            state    <= ST_CWAIT;
                        end
                    end
                end
                ST_PIX0: begin
                    if (pix_hs) begin
                        if (go_pair) begin
                            state <= ST_PIX1;
                        end else begin
                            wcnt     <= single_words(fmt);
                            pix_left <= pix_left - PCNT_W'(1);
                            state    <= ST_SEND;
                        end
                    end
                end
                ST_PIX1: begin
                    if (pix_hs) begin
                        wcnt     <= 2'd3;
                        pix_left <= pix_left - PCNT_W'(2);
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (xfer) begin
                        if (wcnt == 2'd1) begin
                            if (in_frame) begin
                                if (pix_left == '0) begin
                                    done_q   <= 1'b1;
                                    in_frame <= 1'b0;
                                    state    <= ST_IDLE;
                                end else begin
                                    state <= ST_PIX0;
                                end
                            end else begin
                                cmd_left <= cmd_left - LEN_W'(1);
                                state    <= (cmd_left == LEN_W'(1)) ? ST_IDLE : ST_CWAIT;
                            end
                        end else begin
                            wcnt <= wcnt - 2'd1;
                        end
                    end
                end
                ST_CWAIT: begin
                    if (cw_hs) begin
                        wcnt  <= 2'd1;
                        state <= ST_SEND;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if ((state != ST_IDLE) && (start_req || cmd_start))
                berr_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pbs_serializer.sv
module pbs_serializer
    import pbs_pkg::*;
#(
    parameter int PCNT_W = 20,
    parameter int LEN_W  = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_depth,
    input  logic [1:0]        cfg_lines,
    output logic              fmt_err,
    input  logic              start_req,
    input  logic [PCNT_W-1:0] pix_count,
    output logic              frame_busy,
    output logic              frame_done,
    output logic              busy_err,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [23:0]       pix_data,
    input  logic              cmd_start,
    input  logic              cmd_param,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              len_err,
    input  logic              cw_valid,
    output logic              cw_ready,
    input  logic [15:0]       cw_data,
    output logic              bus_req,
    output logic              bus_dc,
    output logic [15:0]       bus_data,
    input  logic              bus_ack
);
    logic       legal;
    fmt_e       fmt;
    logic [4:0] pbits, lbits;
    logic       cap_p0, ld_single, ld_pair, ld_cmd, shift;

    assign fmt_err = !legal;

    pbs_fmt_decode u_dec (
        .depth (depth_e'(cfg_depth)),
        .lines (lines_e'(cfg_lines)),
        .legal (legal),
        .fmt   (fmt),
        .pbits (pbits),
        .lbits (lbits)
    );

    pbs_seq #(.PCNT_W(PCNT_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .legal      (legal),
        .fmt        (fmt),
        .lines      (lines_e'(cfg_lines)),
        .start_req  (start_req),
        .pix_count  (pix_count),
        .cmd_start  (cmd_start),
        .cmd_param  (cmd_param),
        .cmd_len    (cmd_len),
        .pix_valid  (pix_valid),
        .cw_valid   (cw_valid),
        .bus_ack    (bus_ack),
        .pix_ready  (pix_ready),
        .cw_ready   (cw_ready),
        .bus_req    (bus_req),
        .bus_dc     (bus_dc),
        .cap_p0     (cap_p0),
        .ld_single  (ld_single),
        .ld_pair    (ld_pair),
        .ld_cmd     (ld_cmd),
        .shift      (shift),
        .frame_busy (frame_busy),
        .frame_done (frame_done),
        .busy_err   (busy_err),
        .len_err    (len_err)
    );

    pbs_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .pix_data  (pix_data),
        .cw_data   (cw_data),
        .pbits     (pbits),
        .lbits     (lbits),
        .cap_p0    (cap_p0),
        .ld_single (ld_single),
        .ld_pair   (ld_pair),
        .ld_cmd    (ld_cmd),
        .shift     (shift),
        .word      (bus_data)
    );
endmodule

// File: rtl/pbs_serializer_chk.sv
module pbs_serializer_chk (
    input logic        clk,
    input logic        rst,
    input logic        fmt_err,
    input logic        frame_busy,
    input logic        frame_done,
    input logic        busy_err,
    input logic        len_err,
    input logic        pix_ready,
    input logic        cw_ready,
    input logic        bus_req,
    input logic        bus_dc,
    input logic [15:0] bus_data,
    input logic        bus_ack
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_data) && $stable(bus_dc)));

    p_no_fetch_while_req_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (!pix_ready && !cw_ready));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !frame_busy);

    p_frame_dc_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_busy && bus_req) |-> bus_dc);

    p_illegal_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (fmt_err && !frame_busy) |=> !frame_busy);

    p_busy_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> busy_err);

    p_len_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);
endmodule

bind pbs_serializer pbs_serializer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fmt_err    (fmt_err),
    .frame_busy (frame_busy),
    .frame_done (frame_done),
    .busy_err   (busy_err),
    .len_err    (len_err),
    .pix_ready  (pix_ready),
    .cw_ready   (cw_ready),
    .bus_req    (bus_req),
    .bus_dc     (bus_dc),
    .bus_data   (bus_data),
    .bus_ack    (bus_ack)
);

// File: tb/pbs_serializer_bench.sv
`timescale 1ns/1ps
module pbs_serializer_bench;
    localparam int PCNT_W = 20;
    localparam int LEN_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_depth = 2'd1, cfg_lines = 2'd3;
    logic fmt_err, frame_busy, frame_done, busy_err, len_err;
    logic start_req = 1'b0;
    logic [PCNT_W-1:0] pix_count = '0;
    logic pix_valid = 1'b0, pix_ready;
    logic [23:0] pix_data = '0;
    logic cmd_start = 1'b0, cmd_param = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic cw_valid = 1'b0, cw_ready;
    logic [15:0] cw_data = '0;
    logic bus_req, bus_dc, bus_ack;
    logic [15:0] bus_data;

    int total = 0, bad = 0;
    logic [15:0] cap_data [0:63];
    logic        cap_dc   [0:63];
    int cap_n = 0;
    logic [23:0] pix_mem [0:7];
    logic [15:0] cw_mem  [0:7];

    always #2 clk = ~clk;

    pbs_serializer #(.PCNT_W(PCNT_W), .LEN_W(LEN_W)) u_pbs_serializer (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_lines(cfg_lines),
        .fmt_err(fmt_err), .start_req(start_req), .pix_count(pix_count),
        .frame_busy(frame_busy), .frame_done(frame_done), .busy_err(busy_err),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .cmd_start(cmd_start), .cmd_param(cmd_param), .cmd_len(cmd_len),
        .len_err(len_err), .cw_valid(cw_valid), .cw_ready(cw_ready),
        .cw_data(cw_data), .bus_req(bus_req), .bus_dc(bus_dc),
        .bus_data(bus_data), .bus_ack(bus_ack)
    );

    // strobe generator model: one word per acknowledge
    initial begin
        bus_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (cap_n < 64) begin
                    cap_data[cap_n] = bus_data;
                    cap_dc[cap_n]   = bus_dc;
                end
                cap_n = cap_n + 1;
                bus_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pbits_of(int d);
        case (d) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
    endfunction
    function automatic int lbits_of(int l);
        case (l) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
    endfunction
    function automatic logic [15:0] pick(logic [47:0] v, int tot, int L, int j);
        logic [47:0] s;
        s = (v >> (tot - (j + 1) * L)) & ((48'h1 << L) - 48'h1);
        return s[15:0];
    endfunction

    task automatic run_frame(input int d, input int l, input int n, input string tag);
        int P, L, k, idx;
        logic [15:0] exp [0:63];
        logic [47:0] v;
        @(negedge clk);
        cfg_depth = 2'(d); cfg_lines = 2'(l);
        cap_n = 0;
        start_req = 1'b1; pix_count = PCNT_W'(n);
        @(negedge clk);
        start_req = 1'b0;
        if (n == 0) begin
            chk(frame_done == 1'b1, {tag, " R8 zero-count done"}, frame_done, 1);
            chk(frame_busy == 1'b0, {tag, " R8 zero-count busy"}, frame_busy, 0);
        end else begin
            chk(frame_busy == 1'b1, {tag, " R8 busy after start"}, frame_busy, 1);
            for (int i = 0; i < n; i++) begin
                pix_valid = 1'b1; pix_data = pix_mem[i];
                while (!pix_ready) @(negedge clk);
                @(negedge clk);
            end
            pix_valid = 1'b0;
            while (!frame_done) @(negedge clk);
            chk(frame_busy == 1'b0, {tag, " R8 busy clears with done"}, frame_busy, 0);
        end
        @(negedge clk);
        chk(frame_done == 1'b0, {tag, " R8 done is one cycle"}, frame_done, 0);
        // expected words from the requirements
        P = pbits_of(d); L = lbits_of(l); idx = 0; k = 0;
        while (k < n) begin
            if (2 * P == 3 * L && n - k >= 2) begin
                v = (48'(pix_mem[k] & ((24'h1 << P) - 1)) << P) | 48'(pix_mem[k+1] & ((24'h1 << P) - 1));
                for (int j = 0; j < 3; j++) exp[idx++] = pick(v, 2 * P, L, j);
                k += 2;
            end else if (2 * P == 3 * L) begin
                v = 48'(pix_mem[k] & ((24'h1 << P) - 1)) << (2 * L - P);
                for (int j = 0; j < 2; j++) exp[idx++] = pick(v, 2 * L, L, j);
                k += 1;
            end else begin
                v = 48'(pix_mem[k] & ((24'h1 << P) - 1));
                for (int j = 0; j < P / L; j++) exp[idx++] = pick(v, P, L, j);
                k += 1;
            end
        end
        chk(cap_n == idx, {tag, " R9 word count"}, cap_n, idx);
        for (int i = 0; i < idx && i < cap_n; i++) begin
            chk(cap_data[i] == exp[i], {tag, " word"}, cap_data[i], exp[i]);
            chk(cap_dc[i] == 1'b1, {tag, " R10 pixel dc"}, cap_dc[i], 1);
        end
    endtask

    task automatic run_cmd(input int l, input bit param, input int len, input int nw, input string tag);
        int L;
        L = lbits_of(l);
        @(negedge clk);
        cfg_lines = 2'(l);
        cap_n = 0;
        cmd_start = 1'b1; cmd_param = param; cmd_len = LEN_W'(len);
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < nw; i++) begin
            cw_valid = 1'b1; cw_data = cw_mem[i];
            while (!cw_ready) @(negedge clk);
            @(negedge clk);
        end
        cw_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(cap_n == nw, {tag, " R11 word count"}, cap_n, nw);
        chk(bus_req == 1'b0, {tag, " R11 idle after"}, bus_req, 0);
        for (int i = 0; i < nw && i < cap_n; i++) begin
            chk(cap_data[i] == (cw_mem[i] & 16'((32'h1 << L) - 1)), {tag, " R11 word"},
                cap_data[i], cw_mem[i] & 16'((32'h1 << L) - 1));
            chk(cap_dc[i] == param, {tag, " R10 dc"}, cap_dc[i], param);
        end
    endtask

    task automatic t_reset;
        chk(bus_req == 0 && frame_busy == 0 && frame_done == 0, "R1 bus/frame idle",
            {bus_req, frame_busy, frame_done}, 0);
        chk(busy_err == 0 && len_err == 0, "R1 errors clear", {busy_err, len_err}, 0);
        chk(pix_ready == 0 && cw_ready == 0, "R1 not ready", {pix_ready, cw_ready}, 0);
    endtask

    task automatic t_illegal;
        @(negedge clk);
        cfg_depth = 2'd2; cfg_lines = 2'd0;
        cap_n = 0;
        @(negedge clk);
        chk(fmt_err == 1'b1, "R2 18 on 8 illegal", fmt_err, 1);
        start_req = 1'b1; pix_count = 4;
        @(negedge clk);
        start_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(frame_busy == 1'b0 && pix_ready == 1'b0, "R2 start ignored", {frame_busy, pix_ready}, 0);
        chk(cap_n == 0, "R2 nothing sent", cap_n, 0);
        cfg_depth = 2'd3; cfg_lines = 2'd3;
        @(negedge clk);
        chk(fmt_err == 1'b0, "R2 24 on 16 legal", fmt_err, 0);
    endtask

    task automatic t_busy;
        @(negedge clk);
        cfg_depth = 2'd1; cfg_lines = 2'd3;
        cap_n = 0;
        start_req = 1'b1; pix_count = 2;
        @(negedge clk);
        start_req = 1'b0;
        chk(busy_err == 1'b0, "R12 no error yet", busy_err, 0);
        start_req = 1'b1; pix_count = 5;
        @(negedge clk);
        start_req = 1'b0;
        for (int i = 0; i < 2; i++) begin
            pix_valid = 1'b1; pix_data = pix_mem[i];
            while (!pix_ready) @(negedge clk);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        while (!frame_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy_err == 1'b1, "R12 busy_err set", busy_err, 1);
        chk(cap_n == 2, "R12 original count kept", cap_n, 2);
        chk(frame_busy == 1'b0, "R12 frame ended", frame_busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pix_mem[0] = 24'hABCDEF; pix_mem[1] = 24'h123456; pix_mem[2] = 24'h789ABC;
        pix_mem[3] = 24'h0F1E2D; pix_mem[4] = 24'h3C4B5A; pix_mem[5] = 24'h8899AA;
        pix_mem[6] = 24'hFFFFFF; pix_mem[7] = 24'h000001;
        cw_mem[0] = 16'hA52C; cw_mem[1] = 16'h1234; cw_mem[2] = 16'hFE01; cw_mem[3] = 16'h5A5A;
        cw_mem[4] = 16'h0; cw_mem[5] = 16'h0; cw_mem[6] = 16'h0; cw_mem[7] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_frame(3, 3, 3, "R6 R7 24 on 16");
        run_frame(1, 3, 3, "R3 16 on 16");
        run_frame(0, 2, 2, "R3 12 on 12");
        run_frame(1, 0, 3, "R4 16 on 8");
        run_frame(2, 1, 2, "R4 18 on 9");
        run_frame(3, 2, 2, "R4 24 on 12");
        run_frame(3, 0, 2, "R5 24 on 8");
        run_frame(0, 0, 5, "R6 R7 12 on 8");
        run_frame(2, 2, 4, "R6 18 on 12");
        run_frame(3, 3, 1, "R7 single 24 on 16");
        run_frame(1, 3, 0, "R8 zero count");
        t_illegal();
        run_cmd(0, 1'b0, 3, 3, "R10 R11 cmd 8 lines");
        run_cmd(0, 1'b1, 2, 2, "R10 R11 param 8 lines");
        run_cmd(3, 1'b1, 4, 2, "R11 param 16 lines");
        chk(len_err == 1'b0, "R11 no len error yet", len_err, 0);
        run_cmd(3, 1'b0, 3, 0, "R11 odd on 16");
        chk(len_err == 1'b1, "R11 odd length flagged", len_err, 1);
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule